// File: doc/BRIEF.md
# DS3 Alarm Monitor and Interrupt Controller

This block sits next to a DS3 receive framer. Once per received frame it looks at the two X-bits. It also watches parity-error strobes and the level alarms that the framer reports: signal loss, out-of-frame, alarm indication signal, idle and the application-identification channel state. From the X-bits it keeps a filtered far-end receive failure (FERF, also called RDI) defect flag. The live condition of every alarm can be read at any time from a status register.

Each change of an alarm, in either direction, and each parity-error strobe is latched into an interrupt status register. A CPU reads and clears that register over a small synchronous register bus. Each latched bit has its own enable bit. An active-low interrupt pin is driven low while any enabled bit is set.

When automatic return is enabled, the block asks the transmit side to send FERF toward the far end for as long as a near-end signal loss, out-of-frame or alarm indication defect is present.

Top module: `ds3_alarm_irq`

## Requirements
- R1: The FERF flag is declared only after 3 consecutive frame strobes that carry X-bits 00. A frame with mixed X-bits, or with X-bits 11, restarts the count.
- R2: A declared FERF flag clears only after 3 consecutive frame strobes with X-bits 11. X-bit values present while `frameStb` is low have no effect.
- R3: `txFerfReq` equals `autoFerfEn & (los | oof | ais)`. The alarm levels enter through one register stage, so the request follows an alarm one cycle after the alarm input changes.
- R4: Reading address 0 returns the live status with this layout: bit 7 AIS, bit 6 LOS, bit 5 idle, bit 4 OOF, bit 3 always 0, bit 2 FERF, bit 1 AIC state, bit 0 always 0.
- R5: Reading address 1 returns the interrupt status with this layout: bit 7 CP-bit error, bit 6 LOS change, bit 5 AIS change, bit 4 idle change, bit 3 FERF change, bit 2 AIC change, bit 1 OOF change, bit 0 P-bit error. A change bit is set on both the rise and the fall of its condition.
- R6: An interrupt status bit can be set only while the matching bit of the enable register (address 2, read/write) is 1.
- R7: A read of address 1 returns the current interrupt status and clears it to 0. An event that arrives in the same cycle as the read is kept set.
- R8: `irqN` is low exactly when some interrupt status bit and its enable bit are both 1.
- R9: Read data appears on `regRdData` in the cycle after `regRdEn`. After reset the live status, the interrupt status and the enable register are all 0, and `irqN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStb | input | 1 | One-cycle strobe per received frame; qualifies the X-bits |
| xBitA | input | 1 | First X-bit of the frame |
| xBitB | input | 1 | Second X-bit of the frame |
| pErrStb | input | 1 | P-bit parity error strobe |
| cpErrStb | input | 1 | CP-bit parity error strobe |
| losIn | input | 1 | Signal loss defect level |
| oofIn | input | 1 | Out-of-frame defect level |
| aisIn | input | 1 | Alarm indication signal defect level |
| idleIn | input | 1 | Idle condition level |
| aicIn | input | 1 | Application-identification channel state |
| autoFerfEn | input | 1 | Enables automatic FERF return request |
| regAddr | input | 2 | Register address (0 live, 1 interrupt status, 2 enable) |
| regRdEn | input | 1 | Read strobe |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, valid one cycle after the read strobe |
| irqN | output | 1 | Active-low interrupt |
| txFerfReq | output | 1 | Request to the transmit side to send FERF |

## Verification
The bench walks through all eight interrupt sources, first with every enable set and then with only the one source under test masked. This shows that each event reaches the correct bit position, that every level alarm fires on both edges, and that the mask only acts on its own bit. For the FERF filter it sends runs of 0 to 4 all-zero frames, each run broken by a mixed frame, and it also sends clearing runs that are interrupted. This separates a correct 3-frame count from an off-by-one count and from a filter that does not restart on a broken run. All 16 combinations of the auto-return inputs are applied, and a read is placed in the same cycle as an event to show that the event is not lost.

// File: rtl/ds3_alarm_pkg.sv
package ds3_alarm_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_LIVE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_IRQ  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd2;

  // Event strobes: packed order gives the interrupt-status bit layout (bit 7 first).
  typedef struct packed {
    logic cpErr;
    logic losChg;
    logic aisChg;
    logic idleChg;
    logic ferfChg;
    logic aicChg;
    logic oofChg;
    logic pErr;
  } evt_t;

  // Registered alarm levels.
  typedef struct packed {
    logic ais;
    logic los;
    logic idle;
    logic oof;
    logic ferf;
    logic aic;
  } live_t;
endpackage

// File: rtl/ds3_alarm_ctrl.sv
module ds3_alarm_ctrl
  import ds3_alarm_pkg::*;
#(
  parameter int FERF_FRAMES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStb,
  input  logic [1:0] xBits,
  input  logic       pErrStb,
  input  logic       cpErrStb,
  input  logic       losIn,
  input  logic       oofIn,
  input  logic       aisIn,
  input  logic       idleIn,
  input  logic       aicIn,
  output evt_t       evt,
  output live_t      live
);
  localparam int CNT_W = $clog2(FERF_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FERF_FRAMES - 1);

  logic losQ, oofQ, aisQ, idleQ, aicQ;
  logic ferfQ;
  logic [CNT_W-1:0] runCnt;
  logic towardFlip, ferfFlip;

  // Level alarms: one register stage, which also serves as the edge reference.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      losQ  <= 1'b0;
      oofQ  <= 1'b0;
      aisQ  <= 1'b0;
      idleQ <= 1'b0;
      aicQ  <= 1'b0;
    end else begin
      losQ  <= losIn;
      oofQ  <= oofIn;
      aisQ  <= aisIn;
      idleQ <= idleIn;
      aicQ  <= aicIn;
    end
  end

  // FERF filter: count consecutive frames whose X-bits point to the other state.
  always_comb begin
    towardFlip = frameStb && (ferfQ ? (xBits == 2'b11) : (xBits == 2'b00));
    ferfFlip   = towardFlip && (runCnt == CNT_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ferfQ  <= 1'b0;
      runCnt <= '0;
    end else if (frameStb) begin
      if (ferfFlip) begin
        ferfQ  <= ~ferfQ;
        runCnt <= '0;
      end else if (towardFlip) begin
        runCnt <= runCnt + 1'b1;
      end else begin
        runCnt <= '0;
      end
    end
  end

  always_comb begin
    evt.cpErr   = cpErrStb;
    evt.losChg  = losIn  ^ losQ;
    evt.aisChg  = aisIn  ^ aisQ;
    evt.idleChg = idleIn ^ idleQ;
    evt.ferfChg = ferfFlip;
    evt.aicChg  = aicIn  ^ aicQ;
    evt.oofChg  = oofIn  ^ oofQ;
    evt.pErr    = pErrStb;
    live.ais    = aisQ;
    live.los    = losQ;
    live.idle   = idleQ;
    live.oof    = oofQ;
    live.ferf   = ferfQ;
    live.aic    = aicQ;
  end

  // R1 / R2: the FERF flag moves only on an edge that had a frame strobe.
  a_r1_ferf_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    (ferfQ != $past(ferfQ)) |-> $past(frameStb));

  // R2: the run counter never reaches the threshold value.
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < CNT_W'(FERF_FRAMES));
endmodule

// File: rtl/ds3_alarm_dp.sv
module ds3_alarm_dp
  import ds3_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  evt_t              evt,
  input  live_t             live,
  input  logic              autoFerfEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              irqN,
  output logic              txFerfReq
);
  logic [REG_W-1:0] irqStat, irqEn, liveWord, evtMasked, rdMux;
  logic rdClr;

  always_comb begin
    liveWord  = {live.ais, live.los, live.idle, live.oof, 1'b0,
                 live.ferf, live.aic, 1'b0};
    evtMasked = evt & irqEn;
    rdClr     = regRdEn && (regAddr == ADDR_IRQ);
    unique case (regAddr)
      ADDR_LIVE: rdMux = liveWord;
      ADDR_IRQ:  rdMux = irqStat;
      ADDR_IEN:  rdMux = irqEn;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqStat   <= '0;
      irqEn     <= '0;
      regRdData <= '0;
    end else begin
      irqStat <= (rdClr ? '0 : irqStat) | evtMasked;
      if (regWrEn && (regAddr == ADDR_IEN)) irqEn <= regWrData;
      if (regRdEn) regRdData <= rdMux;
    end
  end

  assign irqN      = ~|(irqStat & irqEn);
  assign txFerfReq = autoFerfEn & (live.los | live.oof | live.ais);

  // R6: a bit is never newly set while its enable was clear.
  a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> ((irqStat & ~$past(irqStat) & ~$past(irqEn)) == '0));

  // R7: set bits stay set unless a clearing read took place.
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdClr) |-> ((~irqStat & $past(irqStat)) == '0));

  // R8: a low pin implies a pending status bit.
  a_r8_irq_pending: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (irqStat != '0));

  // R3: no request while auto return is off.
  a_r3_tx_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    txFerfReq |-> autoFerfEn);
endmodule

// File: rtl/ds3_alarm_irq.sv
module ds3_alarm_irq
  import ds3_alarm_pkg::*;
#(
  parameter int FERF_FRAMES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStb,
  input  logic       xBitA,
  input  logic       xBitB,
  input  logic       pErrStb,
  input  logic       cpErrStb,
  input  logic       losIn,
  input  logic       oofIn,
  input  logic       aisIn,
  input  logic       idleIn,
  input  logic       aicIn,
  input  logic       autoFerfEn,
  input  logic [1:0] regAddr,
  input  logic       regRdEn,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irqN,
  output logic       txFerfReq
);
  evt_t  evt;
  live_t live;

  ds3_alarm_ctrl #(.FERF_FRAMES(FERF_FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .xBits({xBitA, xBitB}),
    .pErrStb(pErrStb), .cpErrStb(cpErrStb), .losIn(losIn), .oofIn(oofIn),
    .aisIn(aisIn), .idleIn(idleIn), .aicIn(aicIn), .evt(evt), .live(live)
  );

  ds3_alarm_dp u_dp (
    .clk(clk), .rstN(rstN), .evt(evt), .live(live), .autoFerfEn(autoFerfEn),
    .regAddr(regAddr), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqN(irqN),
    .txFerfReq(txFerfReq)
  );
endmodule

// File: tb/tb_ds3_alarm_irq.sv
module tb_ds3_alarm_irq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStb = 0, xBitA = 0, xBitB = 0, pErrStb = 0, cpErrStb = 0;
  logic losIn = 0, oofIn = 0, aisIn = 0, idleIn = 0, aicIn = 0, autoFerfEn = 0;
  logic [1:0] regAddr = '0;
  logic regRdEn = 0, regWrEn = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irqN, txFerfReq;
  int nChecks = 0, nErr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ds3_alarm_irq dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; regRdEn = 1; step(); regRdEn = 0; d = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1; step(); regWrEn = 0;
  endtask

  task automatic frame(input logic a, input logic b);
    frameStb = 1; xBitA = a; xBitB = b; step(); frameStb = 0; step();
  endtask

  // Interrupt-status bit positions: 7 cp, 6 los, 5 ais, 4 idle, 3 ferf, 2 aic, 1 oof, 0 p
  task automatic fire(input int b, input logic v);
    case (b)
      0: begin pErrStb = 1; step(); pErrStb = 0; end
      1: oofIn = v;
      2: aicIn = v;
      3: for (int k = 0; k < 3; k++) frame(!v, !v);
      4: idleIn = v;
      5: aisIn = v;
      6: losIn = v;
      default: begin cpErrStb = 1; step(); cpErrStb = 0; end
    endcase
    step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] liveExp;
    repeat (3) step();
    rstN = 1; step();

    // R9 reset state
    rd(0, d); chk("R9 live after reset", d, 8'h00);
    rd(1, d); chk("R9 irq after reset", d, 8'h00);
    rd(2, d); chk("R9 enable after reset", d, 8'h00);
    chk("R9 irqN after reset", {7'd0, irqN}, 8'h01);

    // R6: nothing latches while all enables are 0
    fire(0, 1);
    rd(1, d); chk("R6 disabled event", d, 8'h00);

    wr(2, 8'hFF);
    rd(2, d); chk("R9 enable readback", d, 8'hFF);

    // R5 / R8 / R7: sweep every source on rise and fall
    for (int b = 0; b < 8; b++) begin
      for (int v = 1; v >= 0; v--) begin
        fire(b, v[0]);
        chk($sformatf("R8 irqN low src %0d", b), {7'd0, irqN}, 8'h00);
        rd(1, d); chk($sformatf("R5 status src %0d lvl %0d", b, v), d, 8'(1 << b));
        chk($sformatf("R7 irqN after clear src %0d", b), {7'd0, irqN}, 8'h01);
        rd(1, d); chk($sformatf("R7 cleared src %0d", b), d, 8'h00);
      end
    end

    // R6: each source masked alone
    for (int b = 0; b < 8; b++) begin
      wr(2, ~8'(1 << b));
      fire(b, 1);
      rd(1, d); chk($sformatf("R6 masked src %0d", b), d, 8'h00);
      chk($sformatf("R6 irqN masked src %0d", b), {7'd0, irqN}, 8'h01);
      fire(b, 0);
      rd(1, d);
    end
    wr(2, 8'hFF);

    // R4: live layout with each level set alone
    for (int b = 0; b < 5; b++) begin
      losIn = (b == 0); aisIn = (b == 1); idleIn = (b == 2);
      oofIn = (b == 3); aicIn = (b == 4);
      step();
      liveExp = {aisIn, losIn, idleIn, oofIn, 1'b0, 1'b0, aicIn, 1'b0};
      rd(0, d); chk($sformatf("R4 live level %0d", b), d, liveExp);
    end
    aicIn = 0; step();
    rd(1, d);

    // R1: runs of n all-zero frames, each broken by a mixed frame
    for (int n = 0; n <= 4; n++) begin
      for (int k = 0; k < n; k++) frame(0, 0);
      frame(0, 1);
      rd(0, d); chk($sformatf("R1 ferf after %0d zero frames", n), d & 8'h04, (n >= 3) ? 8'h04 : 8'h00);
      rd(1, d); chk($sformatf("R1 ferf event after %0d", n), d, (n >= 3) ? 8'h08 : 8'h00);
      if (n >= 3) begin
        // R2: an interrupted clearing run does not clear
        frame(1, 1); frame(1, 1); frame(0, 0); frame(1, 1); frame(1, 1);
        rd(0, d); chk("R2 broken clear run", d & 8'h04, 8'h04);
        // R2: X-bits without a frame strobe are ignored
        xBitA = 1; xBitB = 1; repeat (5) step();
        rd(0, d); chk("R2 no strobe ignored", d & 8'h04, 8'h04);
        frame(1, 1);
        rd(0, d); chk("R2 cleared after 3 ones", d & 8'h04, 8'h00);
        rd(1, d); chk("R2 clear event", d, 8'h08);
      end
    end

    // R3: all combinations of the auto return inputs
    for (int c = 0; c < 16; c++) begin
      autoFerfEn = c[3]; losIn = c[2]; oofIn = c[1]; aisIn = c[0];
      step();
      chk($sformatf("R3 combo %0d", c), {7'd0, txFerfReq}, {7'd0, c[3] & (c[2] | c[1] | c[0])});
    end
    autoFerfEn = 0; losIn = 0; oofIn = 0; aisIn = 0; step();
    rd(1, d);

    // R7: event in the same cycle as the clearing read wins
    cpErrStb = 1; step(); cpErrStb = 0;
    regAddr = 1; regRdEn = 1; pErrStb = 1; step(); regRdEn = 0; pErrStb = 0;
    chk("R7 read returns old", regRdData, 8'h80);
    rd(1, d); chk("R7 event kept", d, 8'h01);

    // R8: the pin follows the enable mask of a held status bit
    pErrStb = 1; step(); pErrStb = 0;
    wr(2, 8'h00);
    chk("R8 masked pin high", {7'd0, irqN}, 8'h01);
    wr(2, 8'h01);
    chk("R8 unmasked pin low", {7'd0, irqN}, 8'h00);
    rd(1, d); chk("R8 bit held while masked", d, 8'h01);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule